// File: doc/BRIEF.md
# GPIO Pad Function Mux and Configuration Bank

This block holds the control and data state for a small bank of general-purpose pins and turns it into the per-pad signals a pad ring needs: output enable, output level, pull mode and drive-strength code. Software reaches one pin at a time through a simple register port. It gives a pin index and a register select, either the control word or the data word. Writes take effect at the clock edge that samples them. Read data is a combinational function of the current state.

The control word of each pin holds a function-select code, a pull mode, a drive code and a GPIO output-enable bit. Function code 0 is plain GPIO, where the pad follows the GPIO output-enable bit and the stored output value. Any nonzero code hands the pad's output enable and output level to one lane of an alternate-function input port that belongs to that pin. Pull mode and drive code reach the pad in every function. The data word has two bits: a read-only input level, sampled from the pad through a synchronizer, and a writable output value. The output value can be loaded before the pin is turned into an output, so the pad never drives a stale level.

Top module: `gpmx_bank`

## Requirements
- R1: After reset, every pin's control word and data output value read 0. Every pad has output enable 0, pull mode 0 and drive code 0.
- R2: The control word (register select 0) keeps function select in bits [2:0], pull mode in bits [4:3], drive code in bits [7:5] and GPIO output enable in bit 8. A write stores these bits, and a read returns them with every higher bit as 0.
- R3: A pin's pull mode appears on its two pad_pull bits unchanged (0 none, 1 pull-down, 2 bus keeper, 3 pull-up), whatever function is selected.
- R4: A pin's drive code n appears on its three pad_drv bits unchanged, and selects a strength of (n+1)*2 mA: 2 mA for code 0 up to 16 mA for code 7.
- R5: With function 0, pad_oe follows the GPIO output-enable bit and pad_out follows the stored output value. A value written while the pin is an input is already on pad_out in the cycle its output enable first reads 1.
- R6: With function f from 1 to 7, pin p takes pad_oe and pad_out from alt_oe and alt_out bit p*7+(f-1). The GPIO output-enable bit and the output value then have no effect on the pad.
- R7: Data word bit 0 (register select 1) shows pad_in after two clock edges, both while the pin is an input and while it is an output.
- R8: Data word bit 1 is the writable output value. Bit 0 is read-only, so a written bit 0 is ignored. A data write leaves the control word unchanged.
- R9: A write updates the register at the edge that samples bus_wr, and the readback shows the new value before the next edge. A pin index at or above the pin count is ignored on write and reads as 0.
- R10: A write changes only the addressed register of the addressed pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_pin | input | PIN_W | Pin index for the access |
| bus_reg | input | 1 | Register select: 0 control word, 1 data word |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for the addressed register, combinational |
| pad_in | input | NUM_PINS | Raw pad input levels |
| alt_oe | input | NUM_PINS*7 | Alternate-function output enables, 7 lanes per pin |
| alt_out | input | NUM_PINS*7 | Alternate-function output levels, 7 lanes per pin |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_out | output | NUM_PINS | Pad output level |
| pad_pull | output | NUM_PINS*2 | Pad pull mode, 2 bits per pin |
| pad_drv | output | NUM_PINS*3 | Pad drive code, 3 bits per pin |

## Verification
The bench builds the bank with three pins, which leaves pin index 3 encodable on the 2-bit pin bus but outside the bank. That makes the ignored-write and zero-read path for an unpopulated index reachable. Function, pull and drive widths stay at their defaults, so all seven alternate lanes per pin exist. A lane in the middle of the upper pin's slice can then be checked against its neighbours.

// File: rtl/gpmx_pkg.sv
`timescale 1ns/1ps
package gpmx_pkg;

   // register select on the access port
   typedef enum logic {
      GPMX_REG_CTRL = 1'b0,
      GPMX_REG_DATA = 1'b1
   } gpmx_reg_e;

   // pad pull encoding
   typedef enum logic [1:0] {
      GPMX_PULL_NONE   = 2'd0,
      GPMX_PULL_DOWN   = 2'd1,
      GPMX_PULL_KEEPER = 2'd2,
      GPMX_PULL_UP     = 2'd3
   } gpmx_pull_e;

   localparam int GPMX_PULL_W   = 2;
   localparam int GPMX_DIN_BIT  = 0;
   localparam int GPMX_DOUT_BIT = 1;

endpackage

// File: rtl/gpmx_sync.sv
`timescale 1ns/1ps
module gpmx_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain[k] <= '0;
      end else begin
         chain[0] <= d;
         for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      end
   end

   assign q = chain[STAGES-1];

   generate
      if (STAGES == 2) begin : g_lat_chk
         logic [1:0] age;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              age <= 2'd0;
            else if (age != 2'd2)    age <= age + 2'd1;
         end
         AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd2) |-> (q == $past(d, 2))); // R7
      end
   endgenerate

endmodule

// File: rtl/gpmx_pin_regs.sv
`timescale 1ns/1ps
module gpmx_pin_regs #(
   parameter int BUS_W  = 16,
   parameter int CTRL_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_data,
   input  logic [BUS_W-1:0]  wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              out_q
);
   import gpmx_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         out_q  <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
         if (wr_data) out_q  <= wdata[GPMX_DOUT_BIT];
      end
   end

   AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (ctrl_q == $past(wdata[CTRL_W-1:0]))); // R2
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctrl |=> $stable(ctrl_q)); // R8
   AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_data |=> $stable(out_q)); // R10

endmodule

// File: rtl/gpmx_pad_mux.sv
`timescale 1ns/1ps
module gpmx_pad_mux #(
   parameter int FUNC_W = 3,
   parameter int DRV_W  = 3,
   localparam int ALT_CNT  = (1 << FUNC_W) - 1,
   localparam int PULL_LSB = FUNC_W,
   localparam int DRV_LSB  = PULL_LSB + gpmx_pkg::GPMX_PULL_W,
   localparam int OE_BIT   = DRV_LSB + DRV_W,
   localparam int CTRL_W   = OE_BIT + 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [CTRL_W-1:0]             ctrl,
   input  logic                          gpio_out,
   input  logic [ALT_CNT-1:0]            alt_oe,
   input  logic [ALT_CNT-1:0]            alt_out,
   output logic                          pad_oe,
   output logic                          pad_out,
   output logic [gpmx_pkg::GPMX_PULL_W-1:0] pad_pull,
   output logic [DRV_W-1:0]              pad_drv
);

   logic [FUNC_W-1:0] func;
   logic              lane_oe;
   logic              lane_out;

   assign func = ctrl[FUNC_W-1:0];

   always_comb begin
      lane_oe  = 1'b0;
      lane_out = 1'b0;
      for (int f = 1; f <= ALT_CNT; f++) begin
         if (func == FUNC_W'(f)) begin
            lane_oe  = alt_oe[f-1];
            lane_out = alt_out[f-1];
         end
      end
   end

   assign pad_oe   = (func == '0) ? ctrl[OE_BIT] : lane_oe;
   assign pad_out  = (func == '0) ? gpio_out     : lane_out;
   assign pad_pull = ctrl[PULL_LSB +: gpmx_pkg::GPMX_PULL_W];
   assign pad_drv  = ctrl[DRV_LSB +: DRV_W];

   AST_ALT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      ((func != '0) && $stable(func) && $stable(alt_oe) && $stable(alt_out))
      |-> ($stable(pad_oe) && $stable(pad_out))); // R6

endmodule

// File: rtl/gpmx_bank.sv
`timescale 1ns/1ps
module gpmx_bank #(
   parameter int NUM_PINS    = 8,
   parameter int FUNC_W      = 3,
   parameter int DRV_W       = 3,
   parameter int BUS_W       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
   localparam int ALT_CNT = (1 << FUNC_W) - 1,
   localparam int PULL_W  = gpmx_pkg::GPMX_PULL_W,
   localparam int CTRL_W  = FUNC_W + PULL_W + DRV_W + 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_wr,
   input  logic [PIN_W-1:0]            bus_pin,
   input  logic                        bus_reg,
   input  logic [BUS_W-1:0]            bus_wdata,
   output logic [BUS_W-1:0]            bus_rdata,
   input  logic [NUM_PINS-1:0]         pad_in,
   input  logic [NUM_PINS*ALT_CNT-1:0] alt_oe,
   input  logic [NUM_PINS*ALT_CNT-1:0] alt_out,
   output logic [NUM_PINS-1:0]         pad_oe,
   output logic [NUM_PINS-1:0]         pad_out,
   output logic [NUM_PINS*PULL_W-1:0]  pad_pull,
   output logic [NUM_PINS*DRV_W-1:0]   pad_drv
);
   import gpmx_pkg::*;

   // elaboration-time parameter checks
   generate
      if (NUM_PINS < 1)      begin : g_bad_pins  $error("NUM_PINS must be at least 1");          end
      if (FUNC_W < 1)        begin : g_bad_func  $error("FUNC_W must be at least 1");            end
      if (DRV_W < 1)         begin : g_bad_drv   $error("DRV_W must be at least 1");             end
      if (SYNC_STAGES < 2)   begin : g_bad_sync  $error("SYNC_STAGES must be at least 2");       end
      if (CTRL_W > BUS_W)    begin : g_bad_bus   $error("control word does not fit BUS_W");      end
   endgenerate

   logic [NUM_PINS-1:0] wr_ctrl_vec;
   logic [NUM_PINS-1:0] wr_data_vec;
   logic [NUM_PINS-1:0] out_vec;
   logic [NUM_PINS-1:0] in_sync;
   logic [CTRL_W-1:0]   ctrl_arr [NUM_PINS];

   gpmx_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (in_sync)
   );

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         assign wr_ctrl_vec[p] = bus_wr && (bus_pin == PIN_W'(p)) &&
                                 (gpmx_reg_e'(bus_reg) == GPMX_REG_CTRL);
         assign wr_data_vec[p] = bus_wr && (bus_pin == PIN_W'(p)) &&
                                 (gpmx_reg_e'(bus_reg) == GPMX_REG_DATA);

         gpmx_pin_regs #(
            .BUS_W  (BUS_W),
            .CTRL_W (CTRL_W)
         ) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (wr_ctrl_vec[p]),
            .wr_data (wr_data_vec[p]),
            .wdata   (bus_wdata),
            .ctrl_q  (ctrl_arr[p]),
            .out_q   (out_vec[p])
         );

         gpmx_pad_mux #(
            .FUNC_W (FUNC_W),
            .DRV_W  (DRV_W)
         ) u_mux (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl     (ctrl_arr[p]),
            .gpio_out (out_vec[p]),
            .alt_oe   (alt_oe[p*ALT_CNT +: ALT_CNT]),
            .alt_out  (alt_out[p*ALT_CNT +: ALT_CNT]),
            .pad_oe   (pad_oe[p]),
            .pad_out  (pad_out[p]),
            .pad_pull (pad_pull[p*PULL_W +: PULL_W]),
            .pad_drv  (pad_drv[p*DRV_W +: DRV_W])
         );
      end
   endgenerate

   // read path: unpopulated indices fall through to zero
   always_comb begin
      bus_rdata = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (bus_pin == PIN_W'(p)) begin
            if (gpmx_reg_e'(bus_reg) == GPMX_REG_CTRL) begin
               bus_rdata = BUS_W'(ctrl_arr[p]);
            end else begin
               bus_rdata = '0;
               bus_rdata[GPMX_DIN_BIT]  = in_sync[p];
               bus_rdata[GPMX_DOUT_BIT] = out_vec[p];
            end
         end
      end
   end

   AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_ctrl_vec, wr_data_vec})); // R10
   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0)); // R1

endmodule

// File: tb/gpmx_bank_test.sv
`timescale 1ns/1ps
module gpmx_bank_test;

   localparam int NP    = 3;
   localparam int PW    = 2;
   localparam int BW    = 16;
   localparam int ALTN  = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [PW-1:0]     bus_pin = '0;
   logic              bus_reg = 1'b0;
   logic [BW-1:0]     bus_wdata = '0;
   logic [BW-1:0]     bus_rdata;
   logic [NP-1:0]     pad_in = '0;
   logic [NP*ALTN-1:0] alt_oe = '0;
   logic [NP*ALTN-1:0] alt_out = '0;
   logic [NP-1:0]     pad_oe;
   logic [NP-1:0]     pad_out;
   logic [NP*2-1:0]   pad_pull;
   logic [NP*3-1:0]   pad_drv;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   gpmx_bank #(.NUM_PINS(NP)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_pin(bus_pin),
      .bus_reg(bus_reg), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .alt_oe(alt_oe), .alt_out(alt_out),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull(pad_pull), .pad_drv(pad_drv)
   );

   // {pin, reg, wdata, expected readback}
   localparam logic [34:0] VEC [8] = '{
      {2'd0, 1'b0, 16'hFFFF, 16'h01FF},
      {2'd1, 1'b0, 16'h00A5, 16'h00A5},
      {2'd2, 1'b0, 16'h7E18, 16'h0018},
      {2'd0, 1'b0, 16'h0000, 16'h0000},
      {2'd1, 1'b1, 16'hFFFE, 16'h0002},
      {2'd1, 1'b1, 16'h0001, 16'h0000},
      {2'd2, 1'b0, 16'h0155, 16'h0155},
      {2'd3, 1'b0, 16'h01FF, 16'h0000}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      bus_wr = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [PW-1:0] p, input logic r, input logic [BW-1:0] d);
      @(negedge clk);
      bus_pin = p; bus_reg = r; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [PW-1:0] p, input logic r, output logic [BW-1:0] d);
      bus_pin = p; bus_reg = r;
      #0.5;
      d = bus_rdata;
   endtask

   initial begin
      logic [BW-1:0] v;
      do_reset();

      // R1: reset state
      for (int p = 0; p < NP; p++) begin
         rd(PW'(p), 1'b0, v); chk("R1 ctrl", v, 0);
         rd(PW'(p), 1'b1, v); chk("R1 data", v, 0);
      end
      chk("R1 pad_oe", pad_oe, 0);
      chk("R1 pad_pull", pad_pull, 0);
      chk("R1 pad_drv", pad_drv, 0);

      // table walk: R2 R8 R9
      for (int i = 0; i < 8; i++) begin
         logic [34:0] e;
         e = VEC[i];
         wr(e[34:33], e[32], e[31:16]);
         rd(e[34:33], e[32], v);
         chk($sformatf("R2 R8 R9 vector %0d", i), v, e[15:0]);
      end

      do_reset();

      // R3 and R4: pull and drive reach the pads
      wr(2'd1, 1'b0, 16'h00F0);      // pull keeper, drive 7
      chk("R3 keeper", pad_pull[3:2], 2);
      chk("R4 drive7", pad_drv[5:3], 7);
      wr(2'd0, 1'b0, 16'h0008);      // pull down, drive 0
      chk("R3 down", pad_pull[1:0], 1);
      chk("R4 drive0", pad_drv[2:0], 0);
      rd(2'd1, 1'b0, v); chk("R10 neighbour", v, 16'h00F0);

      // R5: preload output value, then enable
      wr(2'd0, 1'b1, 16'h0002);
      chk("R5 still input", pad_oe[0], 0);
      wr(2'd0, 1'b0, 16'h0100);
      chk("R5 oe", pad_oe[0], 1);
      chk("R5 level", pad_out[0], 1);

      // R6: pin 2 function 3 -> lane 2*7+2 = 16
      alt_oe  = '0; alt_oe[16] = 1'b1;
      alt_out = '0; alt_out[20:14] = 7'h7F; alt_out[16] = 1'b0;
      wr(2'd2, 1'b0, 16'h0003);
      chk("R6 alt oe", pad_oe[2], 1);
      chk("R6 alt out", pad_out[2], 0);
      wr(2'd2, 1'b1, 16'h0002);
      chk("R6 gpio ignored", pad_out[2], 0);
      @(negedge clk); alt_out[16] = 1'b1; #0.5;
      chk("R6 alt follow", pad_out[2], 1);

      // R7: two-edge input latency while the pin is an output
      wr(2'd1, 1'b0, 16'h0100);
      @(negedge clk);
      pad_in[1] = 1'b1;
      @(posedge clk); rd(2'd1, 1'b1, v); chk("R7 one edge", v[0], 0);
      @(posedge clk); rd(2'd1, 1'b1, v); chk("R7 two edges", v[0], 1);

      // R8: input bit not writable, ctrl untouched
      @(negedge clk); pad_in[0] = 1'b0;
      wr(2'd0, 1'b1, 16'h0001);
      rd(2'd0, 1'b1, v); chk("R8 ro bit", v, 0);
      rd(2'd0, 1'b0, v); chk("R8 ctrl kept", v, 16'h0100);

      // R9: single-cycle update, before the strobe drops
      @(negedge clk);
      bus_pin = 2'd1; bus_reg = 1'b0; bus_wdata = 16'h0067; bus_wr = 1'b1;
      @(posedge clk); #0.5;
      chk("R9 same cycle", bus_rdata, 16'h0067);
      @(negedge clk); bus_wr = 1'b0;
      wr(2'd3, 1'b0, 16'h01FF);
      rd(2'd3, 1'b0, v); chk("R9 unpopulated", v, 0);
      rd(2'd2, 1'b0, v); chk("R10 pin2 kept", v, 16'h0003);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule